// File: doc/BRIEF.md
# Delayed-Strobe Power Level Store

This block keeps the transmitter's selected power level. The level commands (off, low, medium, high) reach it as short active-high pulses. A rising edge on any command line captures which command is present and starts a delay of `DELAY_CYC` clock cycles. When the delay ends, the block drives an active-low change pulse `PULSE_CYC` cycles wide. The start of that pulse loads the captured command into a mode register, and the register keeps it indefinitely.

Two events skip or cancel this sequence. If the off command rises while a low, medium or high command is still held, the change pulse starts at once and stores off. While the supply-fault input is asserted, no change pulse can exist. The mode register is cleared only by the backup-supply reset. The change pulse is also merged with other strobe sources to form a combined data strobe.

Top module: `pwr_level_store`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode_q` is 4'b0000, `off_stored` is 0 and `chg_pulse_n` is 1.
- R2: A rise on a command line is sampled at clock edge k, with no immediate-off case and no fault. `chg_pulse_n` stays 1 through edge k+DELAY_CYC-1 and is 0 after edge k+DELAY_CYC.
- R3: A change pulse holds `chg_pulse_n` at 0 for exactly PULSE_CYC cycles, then returns it to 1.
- R4: `mode_q` is one-hot or zero. Bit 0 means off, bit 1 low, bit 2 medium, bit 3 high.
- R5: The value loaded is the command captured at the rising edge, even if that command's input has already returned to 0.
- R6: A new command rise during the delay restarts the full delay and replaces the captured command.
- R7: If `cmd_off` rises at edge k while `cmd_low`, `cmd_med` or `cmd_high` is 1, and there is no fault, then after edge k `chg_pulse_n` is 0 and `mode_q` is 4'b0001.
- R8: If `supply_fault` is 1 at an edge, `chg_pulse_n` is 1 after that edge and `mode_q` does not change. A delay that ends under a fault is dropped without loading.
- R9: When several commands are present at the capture edge, the stored value is chosen by precedence: off first, then high, then medium, then low.
- R10: `off_stored` equals 1 exactly when `mode_q` is 4'b0001.
- R11: `data_strobe` is 1 whenever `chg_pulse_n` is 0 or any bit of `ext_strobe` is 1, and 0 otherwise. This is combinational.
- R12: `mode_q` changes only at an edge after which `chg_pulse_n` is 0. Nothing other than reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Backup-supply reset, active low, asynchronous |
| cmd_off | input | 1 | Off command pulse |
| cmd_low | input | 1 | Low level command pulse |
| cmd_med | input | 1 | Medium level command pulse |
| cmd_high | input | 1 | High level command pulse |
| supply_fault | input | 1 | Blocks and cancels change pulses |
| ext_strobe | input | N_EXT_STROBE | Other strobe sources merged into data_strobe |
| mode_q | output | 4 | Stored mode, one-hot |
| off_stored | output | 1 | High while off is stored |
| chg_pulse_n | output | 1 | Active-low change pulse |
| data_strobe | output | 1 | Change pulse ORed with ext_strobe |

## Verification
Two of the block's actions can land on the same edge. One is the end of a running delay, which would load the captured command. The other is a new command rise: either the immediate off case or a restart. Either of these may also coincide with a fault. The directed part of the bench places an off rise during the delay of a held medium command and raises a fault just as a delay expires. The random part keeps command pulses, faults and rises dense enough that such collisions recur. A cycle model in the bench, built from the rules above (new rise beats expiry, immediate off beats restart, fault beats both), judges each edge.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int NUM_CMD  = 4;
    localparam int IDX_OFF  = 0;
    localparam int IDX_LOW  = 1;
    localparam int IDX_MED  = 2;
    localparam int IDX_HIGH = 3;

    typedef logic [NUM_CMD-1:0] cmd_vec_t;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_WAIT  = 2'd1,
        TS_PULSE = 2'd2
    } tmr_state_e;

    localparam cmd_vec_t MODE_OFF = cmd_vec_t'(1) << IDX_OFF;

    // Precedence among simultaneous commands: off, high, medium, low.
    function automatic cmd_vec_t pick_cmd(input cmd_vec_t v);
        cmd_vec_t r;
        r = '0;
        if (v[IDX_OFF])       r[IDX_OFF]  = 1'b1;
        else if (v[IDX_HIGH]) r[IDX_HIGH] = 1'b1;
        else if (v[IDX_MED])  r[IDX_MED]  = 1'b1;
        else if (v[IDX_LOW])  r[IDX_LOW]  = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pls_cmd_capture.sv
module pls_cmd_capture
    import pls_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_vec_t cmd_i,
    output logic     any_rise_o,
    output logic     ovr_o,
    output cmd_vec_t cap_o
);
    typedef struct packed {
        cmd_vec_t prev;
        cmd_vec_t cap;
    } cap_st_t;

    cap_st_t  st_d, st_q;
    cmd_vec_t rise;

    for (genvar g = 0; g < NUM_CMD; g++) begin : g_rise
        assign rise[g] = cmd_i[g] & ~st_q.prev[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = cmd_i;
        if (|rise) st_d.cap = pick_cmd(cmd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_rise_o = |rise;
    // Off rising while another level is still held.
    assign ovr_o      = rise[IDX_OFF] &
                        (cmd_i[IDX_LOW] | cmd_i[IDX_MED] | cmd_i[IDX_HIGH]);
    assign cap_o      = st_q.cap;
endmodule

// File: rtl/pls_strobe_timer.sv
module pls_strobe_timer
    import pls_pkg::*;
#(
    parameter int DELAY_CYC = 20,
    parameter int PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_rise_i,
    input  logic ovr_i,
    input  logic fault_i,
    output logic load_o,
    output logic pulse_o
);
    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] PLS_LD = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        tmr_state_e       state;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (ovr_i && !fault_i) begin
            st_d.state = TS_PULSE;
            st_d.cnt   = PLS_LD;
            load       = 1'b1;
        end else if (any_rise_i) begin
            st_d.state = TS_WAIT;
            st_d.cnt   = DLY_LD;
        end else begin
            unique case (st_q.state)
                TS_WAIT: begin
                    if (st_q.cnt == '0) begin
                        if (fault_i) begin
                            st_d.state = TS_IDLE;
                        end else begin
                            st_d.state = TS_PULSE;
                            st_d.cnt   = PLS_LD;
                            load       = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                TS_PULSE: begin
                    if (fault_i || st_q.cnt == '0) st_d.state = TS_IDLE;
                    else                           st_d.cnt   = st_q.cnt - 1'b1;
                end
                default: st_d.state = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= TS_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = load;
    assign pulse_o = (st_q.state == TS_PULSE);
endmodule

// File: rtl/pls_mode_reg.sv
module pls_mode_reg
    import pls_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  logic     ovr_i,
    input  cmd_vec_t cap_i,
    output cmd_vec_t mode_o
);
    typedef struct packed {
        cmd_vec_t mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.mode = ovr_i ? MODE_OFF : cap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
endmodule

// File: rtl/pwr_level_store.sv
module pwr_level_store
    import pls_pkg::*;
#(
    parameter int DELAY_CYC    = 20,
    parameter int PULSE_CYC    = 10,
    parameter int N_EXT_STROBE = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_off,
    input  logic                    cmd_low,
    input  logic                    cmd_med,
    input  logic                    cmd_high,
    input  logic                    supply_fault,
    input  logic [N_EXT_STROBE-1:0] ext_strobe,
    output logic [3:0]              mode_q,
    output logic                    off_stored,
    output logic                    chg_pulse_n,
    output logic                    data_strobe
);
    cmd_vec_t cmd_vec, cap, mode;
    logic     any_rise, ovr, load, pulse;

    always_comb begin
        cmd_vec           = '0;
        cmd_vec[IDX_OFF]  = cmd_off;
        cmd_vec[IDX_LOW]  = cmd_low;
        cmd_vec[IDX_MED]  = cmd_med;
        cmd_vec[IDX_HIGH] = cmd_high;
    end

    pls_cmd_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_vec),
        .any_rise_o (any_rise),
        .ovr_o      (ovr),
        .cap_o      (cap)
    );

    pls_strobe_timer #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_rise_i (any_rise),
        .ovr_i      (ovr),
        .fault_i    (supply_fault),
        .load_o     (load),
        .pulse_o    (pulse)
    );

    pls_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .ovr_i  (ovr),
        .cap_i  (cap),
        .mode_o (mode)
    );

    assign mode_q      = mode;
    assign off_stored  = mode[IDX_OFF];
    assign chg_pulse_n = ~pulse;
    assign data_strobe = pulse | (|ext_strobe);
endmodule

// File: rtl/pwr_level_store_chk.sv
module pwr_level_store_chk #(
    parameter int N_EXT_STROBE = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_off,
    input logic                    cmd_low,
    input logic                    cmd_med,
    input logic                    cmd_high,
    input logic                    supply_fault,
    input logic [N_EXT_STROBE-1:0] ext_strobe,
    input logic [3:0]              mode_q,
    input logic                    off_stored,
    input logic                    chg_pulse_n,
    input logic                    data_strobe
);
    logic off_prev;
    logic ovr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_prev <= 1'b0;
        else        off_prev <= cmd_off;
    end

    assign ovr_seen = cmd_off & ~off_prev & (cmd_low | cmd_med | cmd_high);

    AST_FAULT_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_fault) |-> chg_pulse_n);                            // R8

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_q));                                               // R4

    AST_MODE_MOVES_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> !chg_pulse_n);                              // R12

    AST_OVERRIDE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_seen && !supply_fault) |=> (!chg_pulse_n && mode_q == 4'b0001)); // R7

    AST_STROBE_COVERS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_pulse_n || (|ext_strobe)) |-> data_strobe);                // R11

    AST_OFF_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        off_stored == (mode_q == 4'b0001));                              // R10
endmodule

bind pwr_level_store pwr_level_store_chk #(.N_EXT_STROBE(N_EXT_STROBE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_off      (cmd_off),
    .cmd_low      (cmd_low),
    .cmd_med      (cmd_med),
    .cmd_high     (cmd_high),
    .supply_fault (supply_fault),
    .ext_strobe   (ext_strobe),
    .mode_q       (mode_q),
    .off_stored   (off_stored),
    .chg_pulse_n  (chg_pulse_n),
    .data_strobe  (data_strobe)
);

// File: tb/pwr_level_store_test.sv
`timescale 1ns/1ps
module pwr_level_store_test;
    localparam int D  = 20;
    localparam int P  = 10;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_off = 0, cmd_low = 0, cmd_med = 0, cmd_high = 0;
    logic          supply_fault = 0;
    logic [NE-1:0] ext_strobe = '0;
    logic [3:0]    mode_q;
    logic          off_stored, chg_pulse_n, data_strobe;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwr_level_store #(.DELAY_CYC(D), .PULSE_CYC(P), .N_EXT_STROBE(NE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_off(cmd_off), .cmd_low(cmd_low),
        .cmd_med(cmd_med), .cmd_high(cmd_high), .supply_fault(supply_fault),
        .ext_strobe(ext_strobe), .mode_q(mode_q), .off_stored(off_stored),
        .chg_pulse_n(chg_pulse_n), .data_strobe(data_strobe)
    );

    // Bench reference: 0 idle, 1 delaying, 2 pulsing.
    logic [3:0] m_prev, m_cap, m_mode, ld_val;
    int         m_st, m_cnt;

    function automatic logic [3:0] prio(input logic [3:0] v);
        if (v[0]) return 4'b0001;
        if (v[3]) return 4'b1000;
        if (v[2]) return 4'b0100;
        if (v[1]) return 4'b0010;
        return 4'b0000;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [3:0] cv, rise;
        logic       ovr, ld;
        if (!rst_n) begin
            m_prev = '0; m_cap = '0; m_mode = '0; m_st = 0; m_cnt = 0;
        end else begin
            cv   = {cmd_high, cmd_med, cmd_low, cmd_off};
            rise = cv & ~m_prev;
            ovr  = rise[0] && (cv[3:1] != 3'b000);
            ld   = 1'b0;
            ld_val = '0;
            if (ovr && !supply_fault) begin
                m_st = 2; m_cnt = P - 1; ld = 1'b1; ld_val = 4'b0001;
            end else if (rise != 0) begin
                m_st = 1; m_cnt = D - 1;
            end else if (m_st == 1) begin
                if (m_cnt == 0) begin
                    if (supply_fault) m_st = 0;
                    else begin m_st = 2; m_cnt = P - 1; ld = 1'b1; ld_val = m_cap; end
                end else m_cnt = m_cnt - 1;
            end else if (m_st == 2) begin
                if (supply_fault || m_cnt == 0) m_st = 0;
                else m_cnt = m_cnt - 1;
            end
            if (ld) m_mode = ld_val;
            if (rise != 0) m_cap = prio(cv);
            m_prev = cv;
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every port against the reference once per cycle.
    task automatic tick();
        @(negedge clk);
        chk("R4 mode",    mode_q, m_mode);
        chk("R10 off",    {3'b0, off_stored}, {3'b0, m_mode == 4'b0001});
        chk("R2 pulse",   {3'b0, chg_pulse_n}, {3'b0, m_st != 2});
        chk("R11 strobe", {3'b0, data_strobe}, {3'b0, (m_st == 2) || (|ext_strobe)});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk("R1 reset mode", mode_q, 4'b0000);
        chk("R1 reset pulse", {3'b0, chg_pulse_n}, 4'b0001);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", {off_stored, 3'b0}, 4'b0000);

        // R2/R3/R5: low pulse, one cycle wide, loaded after it has gone
        cmd_low = 1; tick(); cmd_low = 0;
        ticks(D - 1);
        chk("R2 still waiting", {3'b0, chg_pulse_n}, 4'b0001);
        tick();
        chk("R2 pulse begins", {3'b0, chg_pulse_n}, 4'b0000);
        chk("R5 captured low", mode_q, 4'b0010);
        ticks(P - 1);
        chk("R3 last pulse cycle", {3'b0, chg_pulse_n}, 4'b0000);
        tick();
        chk("R3 pulse over", {3'b0, chg_pulse_n}, 4'b0001);
        ticks(3);

        // R6: restart by a later high command
        cmd_med = 1; tick(); cmd_med = 0;
        ticks(5);
        cmd_high = 1; tick(); cmd_high = 0;
        ticks(D - 1);
        chk("R6 delay restarted", {3'b0, chg_pulse_n}, 4'b0001);
        tick();
        chk("R6 new capture", mode_q, 4'b1000);
        ticks(P + 2);

        // R9: three levels at once, no off
        cmd_low = 1; cmd_med = 1; cmd_high = 1; tick();
        cmd_low = 0; cmd_med = 0; cmd_high = 0;
        ticks(D);
        chk("R9 high wins", mode_q, 4'b1000);
        ticks(P + 2);

        // R7: off arrives while medium held
        cmd_med = 1; ticks(4);
        cmd_off = 1; tick();
        chk("R7 immediate pulse", {3'b0, chg_pulse_n}, 4'b0000);
        chk("R7 off stored", mode_q, 4'b0001);
        chk("R10 off flag", {3'b0, off_stored}, 4'b0001);
        cmd_off = 0; cmd_med = 0;
        ticks(P + 2);

        // R8: fault across a whole delay
        supply_fault = 1;
        cmd_low = 1; tick(); cmd_low = 0;
        for (int i = 0; i < D + 3; i++) begin
            tick();
            chk("R8 blocked", {3'b0, chg_pulse_n}, 4'b0001);
        end
        chk("R8 mode kept", mode_q, 4'b0001);
        supply_fault = 0;
        // R8: fault cuts a running pulse
        cmd_med = 1; tick(); cmd_med = 0;
        ticks(D + 2);
        chk("R8 pulse running", {3'b0, chg_pulse_n}, 4'b0000);
        supply_fault = 1; tick();
        chk("R8 pulse cut", {3'b0, chg_pulse_n}, 4'b0001);
        supply_fault = 0;
        ticks(P);

        // R11/R12: ext strobes only, stored mode untouched
        ext_strobe = 2'b10; tick();
        chk("R11 ext only", {3'b0, data_strobe}, 4'b0001);
        ext_strobe = '0; ticks(20);
        chk("R12 mode retained", mode_q, 4'b0100);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            tick();
            if (cmd_off)  cmd_off  = ($urandom % 2) != 0; else cmd_off  = ($urandom % 30) == 0;
            if (cmd_low)  cmd_low  = ($urandom % 2) != 0; else cmd_low  = ($urandom % 25) == 0;
            if (cmd_med)  cmd_med  = ($urandom % 2) != 0; else cmd_med  = ($urandom % 25) == 0;
            if (cmd_high) cmd_high = ($urandom % 3) != 0; else cmd_high = ($urandom % 25) == 0;
            if (($urandom % 40) == 0) supply_fault = ~supply_fault;
            ext_strobe = (($urandom % 8) == 0) ? NE'($urandom) : '0;
        end
        cmd_off = 0; cmd_low = 0; cmd_med = 0; cmd_high = 0; supply_fault = 0;
        ticks(D + P + 2);

        // R1: backup reset clears the store
        rst_n = 0; tick();
        chk("R1 cleared", mode_q, 4'b0000);
        rst_n = 1; ticks(2);
        chk("R1 stays clear", mode_q, 4'b0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule